// File: doc/BRIEF.md
# LIN Break Detector

This block watches a serial receive line next to an ordinary UART data receiver and spots break fields. A break field is a long run of low bits followed by a return to high. The line is first passed through a synchroniser. The block then uses the same 16x oversampling tick as the data receiver. A falling edge that follows a high line starts a bit run. Every later bit is judged by a majority vote of three mid-bit oversamples. Consecutive low bits are counted. If the count reaches the selected threshold and a high bit is then sampled, a sticky break flag is set. An interrupt output follows that flag while interrupts are enabled.

The block has no data path, so there is no valid/ready interface. All of its pins are plain level or pulse control and status signals. The block has one more duty. When break handling is on and the data receiver reports a framing error, the block raises a hold output that stalls the data receiver. The hold is released on the next sampled high bit. If the low run was too short to be a break, that high bit is simply the line going high again. If a break was recognised, that high bit is the delimiter.

Top module: `lin_brk_det`

## Requirements
- R1: Break detection runs only while both `lin_en` and `rx_en` are 1. With `lin_en` at 0, `rx_hold` stays 0. With either enable at 0, `brk_flag` never sets.
- R2: A bit run starts only on a low level that follows a high level, as seen on the synchronised line after the detector became active. A line that is already low when the detector is enabled does not count.
- R3: The value of each bit, including the start bit, is the majority of oversamples 8, 9 and 10 of its 16. A single-oversample high glitch inside a low bit leaves that bit low.
- R4: With `len_sel` = 0, a break needs at least 10 consecutive low bits, counting the start bit.
- R5: With `len_sel` = 1, a break needs at least 11 consecutive low bits. A run of exactly 10 low bits is not a break in this setting.
- R6: If a high bit is sampled before the threshold is reached, the run is dropped and `brk_flag` is not set. A new run needs a fresh falling edge.
- R7: Reaching the threshold does not set the flag by itself. `brk_flag` sets only when a high bit (the delimiter) is sampled after the threshold. It stays 0 for as long as the line stays low.
- R8: A break is recognised when it starts partway through a character, after earlier data bits.
- R9: `brk_flag` stays set until a one-cycle `flag_clr` pulse clears it. A set event in the same cycle as a clear wins.
- R10: `brk_irq` is 1 exactly while `brk_flag` is 1 and `irq_en` is 1.
- R11: With `lin_en` = 1, a `frame_err` pulse sets `rx_hold` on the next clock. `rx_hold` is released after the next sampled high bit, whether or not the run was long enough to be a break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| rx_en | input | 1 | Receiver enable |
| lin_en | input | 1 | Break handling enable |
| len_sel | input | 1 | Threshold select: 0 means 10 low bits, 1 means 11 low bits |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle pulse that clears `brk_flag` |
| frame_err | input | 1 | Framing-error pulse from the data receiver |
| brk_flag | output | 1 | Sticky break-detected flag |
| brk_irq | output | 1 | Interrupt request |
| rx_hold | output | 1 | Stall request to the data receiver |

## Verification
The detector is driven with low runs of 9, 10 and 11 bits under both threshold settings. These runs separate an off-by-one count from a correct one and show that the select input is obeyed. A 20-bit low run is probed before and after the line goes high, which shows that the flag waits for the delimiter and is not set when the count is reached. Further cases each isolate one part of start detection and sampling:
- a run that begins after data bits;
- a line that is already low when the detector is enabled;
- a one-oversample glitch inside a low bit;
- runs with either enable off.

Framing-error pulses are applied during both complete and incomplete low runs, which shows that the hold is released on the next high bit in both cases.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    SMP_WAIT_HI = 2'd0,
    SMP_ARMED   = 2'd1,
    SMP_RUN     = 2'd2
  } smp_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= d_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign d_out = shreg[STAGES-1];
endmodule

// File: rtl/brk_sampler.sv
module brk_sampler
  import brk_pkg::*;
#(
  parameter int OSR     = 16,
  parameter int SMP_MID = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic rx_s,
  output logic bit_vld,
  output logic bit_val,
  output logic running
);
  localparam int PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam logic [PH_W-1:0] PH_A    = PH_W'(SMP_MID - 2);
  localparam logic [PH_W-1:0] PH_B    = PH_W'(SMP_MID - 1);
  localparam logic [PH_W-1:0] PH_C    = PH_W'(SMP_MID);

  smp_state_e      state;
  logic [PH_W-1:0] phase;
  logic            s_a, s_b;
  logic            vote;

  assign vote    = maj3(s_a, s_b, rx_s);
  assign running = (state == SMP_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SMP_WAIT_HI;
      phase   <= '0;
      s_a     <= 1'b1;
      s_b     <= 1'b1;
      bit_vld <= 1'b0;
      bit_val <= 1'b1;
    end else begin
      bit_vld <= 1'b0;
      if (!enable) begin
        state <= SMP_WAIT_HI;
        phase <= '0;
      end else begin
        unique case (state)
          SMP_WAIT_HI: if (rx_s) state <= SMP_ARMED;
          SMP_ARMED: begin
            if (tick && !rx_s) begin
              state <= SMP_RUN;
              phase <= PH_W'(1);
            end
          end
          SMP_RUN: begin
            if (tick) begin
              if (phase == PH_A) s_a <= rx_s;
              if (phase == PH_B) s_b <= rx_s;
              if (phase == PH_C) begin
                bit_vld <= 1'b1;
                bit_val <= vote;
                if (vote) state <= SMP_WAIT_HI;
              end
              phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
            end
          end
          default: state <= SMP_WAIT_HI;
        endcase
      end
    end
  end
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl #(
  parameter int BRK_SHORT = 10,
  parameter int BRK_LONG  = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic len_sel,
  input  logic bit_vld,
  input  logic bit_val,
  input  logic flag_clr,
  input  logic irq_en,
  output logic brk_set,
  output logic brk_flag,
  output logic brk_irq
);
  localparam int CNT_W = $clog2(BRK_LONG + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(BRK_LONG);

  logic [CNT_W-1:0] zero_cnt;
  logic [CNT_W-1:0] thr;

  assign thr     = len_sel ? CNT_W'(BRK_LONG) : CNT_W'(BRK_SHORT);
  assign brk_set = active && bit_vld && bit_val && (zero_cnt >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_cnt <= '0;
    end else if (!active) begin
      zero_cnt <= '0;
    end else if (bit_vld) begin
      if (bit_val)                  zero_cnt <= '0;
      else if (zero_cnt != CNT_SAT) zero_cnt <= zero_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        brk_flag <= 1'b0;
    else if (brk_set)  brk_flag <= 1'b1;
    else if (flag_clr) brk_flag <= 1'b0;
  end

  assign brk_irq = brk_flag & irq_en;
endmodule

// File: rtl/brk_hold.sv
module brk_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic lin_en,
  input  logic frame_err,
  input  logic bit_one,
  input  logic running,
  output logic rx_hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rx_hold <= 1'b0;
    else if (!lin_en)             rx_hold <= 1'b0;
    else if (frame_err)           rx_hold <= 1'b1;
    else if (bit_one || !running) rx_hold <= 1'b0;
  end
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
  parameter int OSR       = 16,
  parameter int SMP_MID   = 9,
  parameter int SYNC_LEN  = 2,
  parameter int BRK_SHORT = 10,
  parameter int BRK_LONG  = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic rx_in,
  input  logic rx_en,
  input  logic lin_en,
  input  logic len_sel,
  input  logic irq_en,
  input  logic flag_clr,
  input  logic frame_err,
  output logic brk_flag,
  output logic brk_irq,
  output logic rx_hold
);
  logic rx_s;
  logic active;
  logic bit_vld, bit_val, running;
  logic brk_set;

  assign active = lin_en & rx_en;

  brk_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_out(rx_s)
  );

  brk_sampler #(.OSR(OSR), .SMP_MID(SMP_MID)) u_smp (
    .clk(clk), .rst_n(rst_n), .enable(active), .tick(os_tick), .rx_s(rx_s),
    .bit_vld(bit_vld), .bit_val(bit_val), .running(running)
  );

  brk_ctrl #(.BRK_SHORT(BRK_SHORT), .BRK_LONG(BRK_LONG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .active(active), .len_sel(len_sel),
    .bit_vld(bit_vld), .bit_val(bit_val), .flag_clr(flag_clr), .irq_en(irq_en),
    .brk_set(brk_set), .brk_flag(brk_flag), .brk_irq(brk_irq)
  );

  brk_hold u_hold (
    .clk(clk), .rst_n(rst_n), .lin_en(lin_en), .frame_err(frame_err),
    .bit_one(bit_vld & bit_val), .running(running), .rx_hold(rx_hold)
  );
endmodule

// File: rtl/lin_brk_det_chk.sv
module lin_brk_det_chk (
  input logic clk,
  input logic rst_n,
  input logic lin_en,
  input logic rx_en,
  input logic flag_clr,
  input logic frame_err,
  input logic brk_flag,
  input logic rx_hold,
  input logic brk_set,
  input logic bit_vld,
  input logic bit_val
);
  AST_SET_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_set |-> (lin_en && rx_en)); // R1
  AST_HOLD_NEEDS_LIN: assert property (@(posedge clk) disable iff (!rst_n)
    !lin_en |=> !rx_hold); // R1
  AST_SET_ON_DELIM: assert property (@(posedge clk) disable iff (!rst_n)
    brk_set |-> (bit_vld && bit_val)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !flag_clr) |=> brk_flag); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !brk_set) |=> !brk_flag); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_set |=> brk_flag); // R9
  AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_hold) |-> $past(frame_err && lin_en)); // R11
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hold && bit_vld && bit_val && !frame_err) |=> !rx_hold); // R11
endmodule

bind lin_brk_det lin_brk_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lin_en(lin_en), .rx_en(rx_en),
  .flag_clr(flag_clr), .frame_err(frame_err), .brk_flag(brk_flag),
  .rx_hold(rx_hold), .brk_set(brk_set), .bit_vld(bit_vld), .bit_val(bit_val)
);

// File: tb/lin_brk_det_tb.sv
module lin_brk_det_tb;
  localparam int BIT_CLKS = 64;

  logic clk = 1'b0;
  logic rst_n, os_tick, rx_in, rx_en, lin_en, len_sel, irq_en, flag_clr, frame_err;
  logic brk_flag, brk_irq, rx_hold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string req_q[$];
  event  mon_ev;

  always #4 clk = ~clk;

  lin_brk_det u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in), .rx_en(rx_en),
    .lin_en(lin_en), .len_sel(len_sel), .irq_en(irq_en), .flag_clr(flag_clr),
    .frame_err(frame_err), .brk_flag(brk_flag), .brk_irq(brk_irq), .rx_hold(rx_hold)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int nbits);
    rx_in = v;
    repeat (nbits * BIT_CLKS) @(negedge clk);
  endtask

  task automatic run_pattern(input int nzero, input bit exp, input string req);
    hold_line(1'b1, 2);
    hold_line(1'b0, nzero);
    hold_line(1'b1, 3);
    exp_q.push_back(exp);
    req_q.push_back(req);
    -> mon_ev;
    @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ferr();
    frame_err = 1'b1;
    @(negedge clk);
    frame_err = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        bit    e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(brk_flag == e, r, brk_flag, e);
      end
    end
  end

  initial begin
    os_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lin_en = 1'b1; rx_en = 1'b1; len_sel = 1'b0; irq_en = 1'b0;
    flag_clr = 1'b0; frame_err = 1'b0; rx_in = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(brk_flag == 1'b0, "R9 reset flag", brk_flag, 0);
    chk(brk_irq == 1'b0, "R10 reset irq", brk_irq, 0);
    chk(rx_hold == 1'b0, "R11 reset hold", rx_hold, 0);

    // R4: 10 zeros with short threshold
    run_pattern(10, 1'b1, "R4 ten zeros");
    irq_en = 1'b1;
    @(negedge clk);
    chk(brk_irq == 1'b1, "R10 irq with enable", brk_irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk(brk_irq == 1'b0, "R10 irq masked", brk_irq, 0);
    hold_line(1'b1, 3);
    chk(brk_flag == 1'b1, "R9 flag sticky", brk_flag, 1);
    clear_flag();
    chk(brk_flag == 1'b0, "R9 flag cleared", brk_flag, 0);

    // R6: too short
    run_pattern(9, 1'b0, "R6 nine zeros");

    // R5: long threshold
    len_sel = 1'b1;
    run_pattern(10, 1'b0, "R5 ten zeros long sel");
    run_pattern(11, 1'b1, "R5 eleven zeros long sel");
    clear_flag();
    len_sel = 1'b0;

    // R7: delimiter required
    hold_line(1'b1, 2);
    hold_line(1'b0, 18);
    chk(brk_flag == 1'b0, "R7 no flag while low", brk_flag, 0);
    hold_line(1'b0, 2);
    chk(brk_flag == 1'b0, "R7 still low", brk_flag, 0);
    hold_line(1'b1, 3);
    chk(brk_flag == 1'b1, "R7 flag after delimiter", brk_flag, 1);
    clear_flag();

    // R3: one-oversample glitch inside a low bit
    hold_line(1'b1, 2);
    hold_line(1'b0, 4);
    rx_in = 1'b0;
    repeat (34) @(negedge clk);
    rx_in = 1'b1;
    repeat (4) @(negedge clk);
    rx_in = 1'b0;
    repeat (BIT_CLKS - 38) @(negedge clk);
    hold_line(1'b0, 5);
    hold_line(1'b1, 3);
    chk(brk_flag == 1'b1, "R3 majority rejects glitch", brk_flag, 1);
    clear_flag();

    // R1: enables
    lin_en = 1'b0;
    run_pattern(12, 1'b0, "R1 lin disabled");
    lin_en = 1'b1;
    rx_en = 1'b0;
    run_pattern(12, 1'b0, "R1 rx disabled");
    rx_en = 1'b1;

    // R2: line already low at enable
    hold_line(1'b1, 1);
    lin_en = 1'b0;
    hold_line(1'b0, 2);
    lin_en = 1'b1;
    hold_line(1'b0, 12);
    hold_line(1'b1, 3);
    chk(brk_flag == 1'b0, "R2 no edge no run", brk_flag, 0);
    run_pattern(10, 1'b1, "R2 fresh edge after high");
    clear_flag();

    // R8: break after data bits
    hold_line(1'b1, 2);
    hold_line(1'b0, 1);
    hold_line(1'b1, 1);
    hold_line(1'b0, 1);
    hold_line(1'b1, 2);
    hold_line(1'b0, 10);
    hold_line(1'b1, 3);
    chk(brk_flag == 1'b1, "R8 break mid frame", brk_flag, 1);
    clear_flag();

    // R11: hold during complete break
    hold_line(1'b1, 2);
    hold_line(1'b0, 5);
    pulse_ferr();
    chk(rx_hold == 1'b1, "R11 hold set", rx_hold, 1);
    hold_line(1'b0, 6);
    chk(rx_hold == 1'b1, "R11 hold kept while low", rx_hold, 1);
    hold_line(1'b1, 2);
    chk(rx_hold == 1'b0, "R11 hold released at delimiter", rx_hold, 0);
    chk(brk_flag == 1'b1, "R7 flag with hold case", brk_flag, 1);
    clear_flag();

    // R11: hold during incomplete run
    hold_line(1'b1, 2);
    hold_line(1'b0, 3);
    pulse_ferr();
    chk(rx_hold == 1'b1, "R11 hold set short run", rx_hold, 1);
    hold_line(1'b1, 2);
    chk(rx_hold == 1'b0, "R11 hold released on high", rx_hold, 0);
    chk(brk_flag == 1'b0, "R6 short run no flag", brk_flag, 0);

    // R1: no hold with lin disabled
    lin_en = 1'b0;
    hold_line(1'b0, 2);
    pulse_ferr();
    chk(rx_hold == 1'b0, "R1 no hold without lin", rx_hold, 0);
    hold_line(1'b1, 1);
    lin_en = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule